// File: doc/BRIEF.md
# Energy-Minimising Cache Configuration Selector

Once per decision interval this engine walks every candidate cache configuration: the product of the size states (full, half, quarter and eighth of the sets) and the active-way counts (1 up to the full associativity). For each candidate it reads a predicted execution time and a predicted energy from an estimate table that lies outside the block. It then drops any candidate whose predicted slowdown, relative to the full-size configuration with all ways active, reaches a percentage threshold. Among the candidates that remain it keeps the one with the lowest energy.

A start pulse begins a scan. The engine first reads the baseline entry and then issues one table address per clock. The table must return the addressed entry in the same cycle. At the end of the scan it updates its configuration outputs and raises a one-cycle done strobe. If every candidate is rejected, the engine keeps the configuration it already had and raises a flag. The estimates themselves are produced elsewhere.

Top module: `cfg_energy_select`

## Requirements
- R1: After reset the configuration outputs read size code 0 (full) with all WAYS ways active, and `done` and `none_fit` are low.
- R2: Table index = size_code × WAYS + (ways − 1), where size codes are 0 full, 1 half, 2 quarter and 3 eighth. In the cycle after start is sampled, `tbl_addr` shows the baseline index WAYS−1. In the following WAYS×SIZES cycles it shows 0, 1, 2 and so on in ascending order, so size is the outer loop and ways the inner loop.
- R3: A candidate is rejected when (T − Tbase) × 100 ≥ threshold × Tbase, with T and Tbase taken as unsigned times. A slowdown exactly at the threshold is rejected, and a candidate faster than the baseline always passes when the threshold is above zero.
- R4: Among the passing candidates, the one with the lowest energy is chosen. On equal energy, the one earliest in scan order wins.
- R5: If no candidate passes, the configuration outputs keep their previous values and `none_fit` goes high. A scan in which some candidate passes clears `none_fit`.
- R6: `done` is high for exactly one cycle, WAYS×SIZES+1 clock edges after the edge that samples start. The new configuration is visible in that same cycle.
- R7: A start pulse during a scan is ignored. The scan neither restarts nor produces a second done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a scan (sampled when idle) |
| thresh_pct | input | THR_W | Slowdown limit in percent |
| tbl_addr | output | IDX_W | Estimate table index being read |
| tbl_time | input | TIME_W | Predicted time of addressed entry |
| tbl_energy | input | EN_W | Predicted energy of addressed entry |
| cfg_size | output | 2 | Chosen size code (0 full … 3 eighth) |
| cfg_ways | output | WAY_W | Chosen active-way count |
| none_fit | output | 1 | Last scan found no passing candidate |
| done | output | 1 | One-cycle end-of-scan strobe |

## Verification
The bench uses the default build of 8 ways, four sizes and 16-bit times and energies. At that size a single scan covers all 32 candidates, so each run compares the full table against an arithmetic model. Tables are built to place a slowdown exactly on the threshold, to create energy ties, to include candidates faster than the baseline, and to give a threshold of zero that rejects everything. Together these reach the equality edge of the filter, the tie rule, the fallback when nothing fits and recovery from it.

// File: rtl/cfg_sel_pkg.sv
// Shared types for the configuration selector.
package cfg_sel_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_BASE = 2'd1,
        PH_SCAN = 2'd2
    } phase_e;
endpackage

// File: rtl/cfg_scan_ctrl.sv
// Scan sequencer: on start, one baseline read, then one candidate index per
// clock in ascending order. Assumes the table answers in the same cycle.
module cfg_scan_ctrl
    import cfg_sel_pkg::*;
#(
    parameter int NCAND = 32,
    parameter int IDX_W = $clog2(NCAND)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output phase_e           phase,
    output logic [IDX_W-1:0] idx,
    output logic             base_ld,
    output logic             cand_vld,
    output logic             last
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NCAND - 1);

    assign base_ld  = (phase == PH_BASE);
    assign cand_vld = (phase == PH_SCAN);
    assign last     = cand_vld && (idx == LAST_IDX);

    // Phase and index sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            idx   <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: if (start) phase <= PH_BASE;
                PH_BASE: begin
                    phase <= PH_SCAN;
                    idx   <= '0;
                end
                PH_SCAN: begin
                    if (last) phase <= PH_IDLE;
                    idx <= idx + 1'b1;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R2
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_vld && !last) |=> (cand_vld && idx == $past(idx) + 1'b1));
    // R7
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cand_vld |=> (phase != PH_BASE));
endmodule

// File: rtl/cfg_slow_filter.sv
// Slowdown filter: passes a candidate when (T - Tbase)*100 < thr*Tbase,
// evaluated in signed arithmetic wide enough that nothing overflows.
module cfg_slow_filter #(
    parameter int TIME_W = 16,
    parameter int THR_W  = 7
) (
    input  logic [TIME_W-1:0] base_time,
    input  logic [TIME_W-1:0] cand_time,
    input  logic [THR_W-1:0]  thr,
    output logic              pass
);
    localparam int PW = TIME_W + THR_W + 9;
    localparam logic signed [PW-1:0] HUNDRED = PW'(100);

    logic signed [PW-1:0] diff, lhs, rhs;

    // Cross-multiplied percentage comparison.
    always_comb begin
        diff = $signed({{(PW-TIME_W){1'b0}}, cand_time})
             - $signed({{(PW-TIME_W){1'b0}}, base_time});
        lhs  = diff * HUNDRED;
        rhs  = $signed({{(PW-THR_W){1'b0}}, thr})
             * $signed({{(PW-TIME_W){1'b0}}, base_time});
        pass = (lhs < rhs);
    end
endmodule

// File: rtl/cfg_best_track.sv
// Running minimum of energy over passing candidates; empty after clr.
// Strict comparison keeps the earliest candidate on ties.
module cfg_best_track #(
    parameter int EN_W  = 16,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             cand_vld,
    input  logic             pass,
    input  logic [EN_W-1:0]  energy,
    input  logic [IDX_W-1:0] idx,
    output logic             nx_vld,
    output logic [IDX_W-1:0] nx_idx
);
    logic             best_vld;
    logic [EN_W-1:0]  best_en;
    logic [IDX_W-1:0] best_idx;
    logic             take;

    // Decide whether the current candidate displaces the holder.
    always_comb begin
        take   = cand_vld && pass && (!best_vld || energy < best_en);
        nx_vld = best_vld || take;
        nx_idx = take ? idx : best_idx;
    end

    // Hold the best candidate so far.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            best_vld <= 1'b0;
            best_en  <= '0;
            best_idx <= '0;
        end else if (take) begin
            best_vld <= 1'b1;
            best_en  <= energy;
            best_idx <= idx;
        end
    end

    // R4
    en_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (best_vld && !clr) |=> (best_vld && best_en <= $past(best_en)));
endmodule

// File: rtl/cfg_energy_select.sv
// Top: sequences a scan over SIZES x WAYS candidates, filters on slowdown
// against the full-size all-ways baseline, keeps the minimum energy and
// publishes the result with a one-cycle done. Table read is combinational.
module cfg_energy_select
    import cfg_sel_pkg::*;
#(
    parameter int WAYS   = 8,
    parameter int SIZES  = 4,
    parameter int TIME_W = 16,
    parameter int EN_W   = 16,
    parameter int THR_W  = 7,
    parameter int NCAND  = WAYS * SIZES,
    parameter int IDX_W  = $clog2(NCAND),
    parameter int WAY_W  = $clog2(WAYS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [THR_W-1:0]  thresh_pct,
    output logic [IDX_W-1:0]  tbl_addr,
    input  logic [TIME_W-1:0] tbl_time,
    input  logic [EN_W-1:0]   tbl_energy,
    output logic [1:0]        cfg_size,
    output logic [WAY_W-1:0]  cfg_ways,
    output logic              none_fit,
    output logic              done
);
    localparam int WB = $clog2(WAYS);
    localparam logic [IDX_W-1:0] BASE_IDX = IDX_W'(WAYS - 1);

    phase_e            phase;
    logic [IDX_W-1:0]  idx;
    logic              base_ld, cand_vld, last, pass, nx_vld;
    logic [IDX_W-1:0]  nx_idx;
    logic [TIME_W-1:0] base_time;

    cfg_scan_ctrl #(.NCAND(NCAND), .IDX_W(IDX_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .phase(phase), .idx(idx),
        .base_ld(base_ld), .cand_vld(cand_vld), .last(last)
    );

    assign tbl_addr = base_ld ? BASE_IDX : idx;

    // Capture the baseline time.
    always_ff @(posedge clk) begin
        if (!rst_n)       base_time <= '0;
        else if (base_ld) base_time <= tbl_time;
    end

    cfg_slow_filter #(.TIME_W(TIME_W), .THR_W(THR_W)) u_filt (
        .base_time(base_time), .cand_time(tbl_time), .thr(thresh_pct), .pass(pass)
    );

    cfg_best_track #(.EN_W(EN_W), .IDX_W(IDX_W)) u_best (
        .clk(clk), .rst_n(rst_n), .clr(base_ld), .cand_vld(cand_vld),
        .pass(pass), .energy(tbl_energy), .idx(idx),
        .nx_vld(nx_vld), .nx_idx(nx_idx)
    );

    // Publish the result at the last candidate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_size <= 2'd0;
            cfg_ways <= WAY_W'(WAYS);
            none_fit <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= last;
            if (last) begin
                if (nx_vld) begin
                    cfg_size <= 2'(nx_idx >> WB);
                    cfg_ways <= WAY_W'(nx_idx[WB-1:0]) + 1'b1;
                    none_fit <= 1'b0;
                end else begin
                    none_fit <= 1'b1;
                end
            end
        end
    end

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R5
    keep_on_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && none_fit) |-> ($stable(cfg_size) && $stable(cfg_ways)));
    // R6
    cfg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(cfg_size) && $stable(cfg_ways)));
    // R1
    ways_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ways >= 1 && cfg_ways <= WAY_W'(WAYS)));
endmodule

// File: tb/sim_cfg_energy_select.sv
module sim_cfg_energy_select;
    localparam int N = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [6:0]  thr = 7'd3;
    logic [4:0]  addr;
    logic [15:0] tt [N];
    logic [15:0] ee [N];
    logic [15:0] t_rd, e_rd;
    logic [1:0]  sz;
    logic [3:0]  wy;
    logic        nf, dn;
    int          nchk = 0, nfail = 0;
    int          exp_sz = 0, exp_wy = 8, exp_nf = 0;

    always #5 clk = ~clk;

    assign t_rd = tt[addr];
    assign e_rd = ee[addr];

    cfg_energy_select u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .thresh_pct(thr),
        .tbl_addr(addr), .tbl_time(t_rd), .tbl_energy(e_rd),
        .cfg_size(sz), .cfg_ways(wy), .none_fit(nf), .done(dn)
    );

    task automatic check(string req, longint act, longint exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Arithmetic model of the whole scan.
    task automatic model();
        longint tb, bi;
        longint be;
        bi = -1;
        be = 0;
        tb = tt[7];
        for (int i = 0; i < N; i++) begin
            longint d;
            d = (longint'(tt[i]) - tb) * 100;
            if (d < longint'(thr) * tb) begin
                if (bi < 0 || longint'(ee[i]) < be) begin
                    bi = i;
                    be = ee[i];
                end
            end
        end
        if (bi < 0) exp_nf = 1;
        else begin
            exp_nf = 0;
            exp_sz = int'(bi / 8);
            exp_wy = int'(bi % 8) + 1;
        end
    endtask

    // One scan with timing, address-trace and result checks.
    task automatic run(string tag, bit restart);
        int dcount;
        model();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        dcount = 0;
        for (int k = 1; k <= 36; k++) begin
            if (k == 1) check({"R2 base addr ", tag}, addr, 7);
            else if (k <= 33) check({"R2 scan addr ", tag}, addr, k - 2);
            if (restart && k == 10) start = 1'b1;
            if (restart && k == 11) start = 1'b0;
            if (dn) begin
                dcount++;
                check({"R6 done cycle ", tag}, k, 34);
                check({"R4 size ", tag}, sz, exp_sz);
                check({"R4 ways ", tag}, wy, exp_wy);
                check({"R5 none_fit ", tag}, nf, exp_nf);
            end
            @(negedge clk);
        end
        check({"R7 R6 done count ", tag}, dcount, 1);
    endtask

    function automatic void fill_rand(int base);
        for (int i = 0; i < N; i++) begin
            tt[i] = 16'(base + $urandom_range(0, base / 10));
            ee[i] = 16'($urandom_range(100, 60000));
        end
        tt[7] = 16'(base);
    endfunction

    initial begin
        for (int i = 0; i < N; i++) begin tt[i] = 16'd1000; ee[i] = 16'd500; end
        repeat (3) @(negedge clk);
        check("R1 size", sz, 0);
        check("R1 ways", wy, 8);
        check("R1 none_fit", nf, 0);
        check("R1 done", dn, 0);
        rst_n = 1'b1;

        // Random tables at several thresholds.
        for (int r = 0; r < 12; r++) begin
            fill_rand(1000 + 300 * r);
            thr = 7'(r % 8);
            run("R3 random", 1'b0);
        end

        // Exact-threshold edge: only entries strictly under 3% survive.
        thr = 7'd3;
        for (int i = 0; i < N; i++) begin tt[i] = 16'd1030; ee[i] = 16'(10 + i); end
        tt[7] = 16'd1000; ee[7] = 16'd900;
        tt[20] = 16'd1029; ee[20] = 16'd800;
        run("R3 equal edge", 1'b0);
        check("R3 edge pick", exp_sz * 8 + exp_wy - 1, 20);

        // Faster than baseline passes; ties keep the earliest.
        for (int i = 0; i < N; i++) begin tt[i] = 16'd5000; ee[i] = 16'd40; end
        tt[7] = 16'd1000; ee[7] = 16'd300;
        tt[12] = 16'd500; ee[12] = 16'd50;
        tt[25] = 16'd900; ee[25] = 16'd50;
        tt[30] = 16'd999; ee[30] = 16'd50;
        run("R4 tie", 1'b0);
        check("R4 tie earliest", exp_sz * 8 + exp_wy - 1, 12);

        // Threshold zero rejects everything: keep config, flag.
        thr = 7'd0;
        for (int i = 0; i < N; i++) tt[i] = 16'd2000;
        run("R5 none", 1'b0);
        check("R5 flagged", exp_nf, 1);
        check("R5 size kept", sz, 1);
        check("R5 ways kept", wy, 5);

        // Recovery, with a start pulse in mid-scan.
        thr = 7'd3;
        fill_rand(4000);
        run("R7 restart", 1'b1);
        check("R5 cleared", nf, 0);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule